// File: doc/BRIEF.md
# Stack and Register-Pair Byte Sequencer

This block carries out the memory side of 16-bit register-pair operations on a processor whose data bus is 8 bits wide. A command names one of six operations: push a pair, pop a pair, swap HL with the two bytes on top of the stack, load HL from a direct address, store HL to a direct address, or copy HL into the stack pointer. The block then walks through the needed byte accesses, one per clock, on a single-port memory interface.

The caller presents the command code, the direct address, the pair value, HL and the stack pointer together with a valid strobe. The block latches them, raises busy, and issues its reads and writes in a fixed order. It finishes with a one-cycle done pulse. The updated pair, HL and stack pointer values are valid in the done cycle and are held until the next command is accepted. Memory read data is taken in the same cycle as the read strobe.

Top module: `pair_mem_seq`

## Requirements
- R1: After reset, busy, done, mem_rd and mem_wr are low and pair_out, hl_out and sp_out are zero.
- R2: A command is accepted on a clock edge where cmd_valid is high and busy is low. Busy is high from the next cycle through the done cycle, and cmd_valid is ignored while busy is high. The codes are 0 push, 1 pop, 2 swap-with-stack-top, 3 load HL direct, 4 store HL direct and 5 copy HL to SP. Codes 6 and 7 finish with no memory access and return the inputs unchanged.
- R3: Each access takes one cycle, and mem_rd and mem_wr are never high together. Push, pop, load and store make 2 accesses, swap makes 4 and copy makes none. Done is a single-cycle pulse in the cycle after the last access.
- R4: Push writes pair_in[15:8] to SP-1 and then pair_in[7:0] to SP-2, and sp_out becomes SP-2. For the accumulator/flags pair, the accumulator is bits [15:8] and the flags are bits [7:0].
- R5: Pop reads the byte at SP into pair_out[7:0] and then the byte at SP+1 into pair_out[15:8], and sp_out becomes SP+2.
- R6: Swap reads SP and SP+1, then writes the old L to SP and the old H to SP+1. hl_out takes the bytes read, with the SP byte low, and sp_out equals SP.
- R7: Load HL direct reads the address into L and the address+1 into H, with no write.
- R8: Store HL direct writes L to the address and H to the address+1, and hl_out equals hl_in.
- R9: Copy HL to SP sets sp_out to hl_in with no memory access, and done comes one cycle after accept.
- R10: All stack pointer arithmetic and every address+1 wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 16 | Direct address for load/store HL |
| pair_in | input | 16 | Pair value for push |
| hl_in | input | 16 | Current HL |
| sp_in | input | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, same cycle as mem_rd |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pair_out | output | 16 | Updated pair (pop result) |
| hl_out | output | 16 | Updated HL |
| sp_out | output | 16 | Updated stack pointer |

## Verification
Each command is run with distinct high and low bytes and distinct memory bytes at the two addresses. A swapped byte order or an off-by-one address therefore shows up as a wrong value, not as a match by accident. Push and pop are run with the stack pointer at 0x0001 and 0xFFFF, and load uses address 0xFFFF, to separate 16-bit wrap from carry into a wider field. A second command raised mid-push checks that busy masks the request. Copy and an unused code show that no memory strobe appears when none is due.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    OP_PUSH     = 3'd0,
    OP_POP      = 3'd1,
    OP_SWAP_TOP = 3'd2,
    OP_LOAD_HL  = 3'd3,
    OP_STORE_HL = 3'd4,
    OP_HL_TO_SP = 3'd5
  } pms_op_e;

  // number of byte accesses a command needs
  function automatic logic [2:0] op_steps(pms_op_e op);
    case (op)
      OP_PUSH, OP_POP, OP_LOAD_HL, OP_STORE_HL: op_steps = 3'd2;
      OP_SWAP_TOP:                              op_steps = 3'd4;
      default:                                  op_steps = 3'd0;
    endcase
  endfunction

  // signed offset from the base address for a given step
  function automatic int step_offset(pms_op_e op, logic [1:0] s);
    if (op == OP_PUSH) step_offset = (s == 2'd0) ? -1 : -2;
    else               step_offset = s[0] ? 1 : 0;
  endfunction

  function automatic logic step_writes(pms_op_e op, logic [1:0] s);
    case (op)
      OP_PUSH, OP_STORE_HL: step_writes = 1'b1;
      OP_SWAP_TOP:          step_writes = s[1];
      default:              step_writes = 1'b0;
    endcase
  endfunction

  // which byte of the 16-bit value a step moves
  function automatic logic step_high(pms_op_e op, logic [1:0] s);
    if (op == OP_PUSH) step_high = (s == 2'd0);
    else               step_high = s[0];
  endfunction

  function automatic logic op_uses_hl(pms_op_e op);
    op_uses_hl = (op == OP_SWAP_TOP) || (op == OP_LOAD_HL) ||
                 (op == OP_STORE_HL) || (op == OP_HL_TO_SP);
  endfunction

endpackage

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  output logic       accept,
  output logic       run,
  output logic       last,
  output logic       busy,
  output logic       done,
  output logic [1:0] step,
  output pms_op_e    op_q
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;
  st_e st_q;

  assign busy   = (st_q != ST_IDLE);
  assign done   = (st_q == ST_FIN);
  assign run    = (st_q == ST_RUN);
  assign accept = (st_q == ST_IDLE) && cmd_valid;
  assign last   = run && (({1'b0, step} + 3'd1) == op_steps(op_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      step <= '0;
      op_q <= OP_PUSH;
    end else begin
      case (st_q)
        ST_IDLE: if (cmd_valid) begin
          op_q <= pms_op_e'(cmd_op);
          step <= '0;
          st_q <= (op_steps(pms_op_e'(cmd_op)) == 3'd0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (last) begin
            st_q <= ST_FIN;
            step <= '0;
          end else begin
            step <= step + 2'd1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // done lasts one cycle and is followed by idle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // a busy cycle never takes a new command
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy && $stable(op_q));
endmodule

// File: rtl/pms_agen.sv
module pms_agen
  import pms_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            run,
  input  pms_op_e         op,
  input  logic [1:0]      step,
  input  logic [AW-1:0]   base,
  input  logic [2*BW-1:0] pair_src,
  input  logic [2*BW-1:0] hl_src,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata,
  output logic            mem_rd,
  output logic            mem_wr
);
  logic [2*BW-1:0] src;
  logic            wr_step;

  assign wr_step  = step_writes(op, step);
  assign src      = op_uses_hl(op) ? hl_src : pair_src;
  assign mem_wr   = run && wr_step;
  assign mem_rd   = run && !wr_step;
  assign mem_addr = run ? base + AW'(step_offset(op, step)) : '0;
  assign mem_wdata = (run && wr_step) ?
                     (step_high(op, step) ? src[2*BW-1:BW] : src[BW-1:0]) : '0;

  always_comb begin
    a_strobe_excl_r3: assert (!(mem_rd && mem_wr));
  end
endmodule

// File: rtl/pms_regs.sv
module pms_regs
  import pms_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            done,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [2*BW-1:0] pair_in,
  input  logic [2*BW-1:0] hl_in,
  input  logic [AW-1:0]   sp_in,
  input  pms_op_e         op,
  input  logic [1:0]      step,
  input  logic            rd_fire,
  input  logic [BW-1:0]   mem_rdata,
  output logic [AW-1:0]   base,
  output logic [2*BW-1:0] pair_src,
  output logic [2*BW-1:0] hl_src,
  output logic [2*BW-1:0] pair_out,
  output logic [2*BW-1:0] hl_out,
  output logic [AW-1:0]   sp_out
);
  pms_op_e new_op;
  assign new_op = pms_op_e'(cmd_op);

  function automatic logic [AW-1:0] final_sp(pms_op_e o, logic [AW-1:0] sp,
                                             logic [2*BW-1:0] hl);
    case (o)
      OP_PUSH:     final_sp = sp - AW'(2);
      OP_POP:      final_sp = sp + AW'(2);
      OP_HL_TO_SP: final_sp = AW'(hl);
      default:     final_sp = sp;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0; pair_src <= '0; hl_src <= '0;
      pair_out <= '0; hl_out <= '0; sp_out <= '0;
    end else if (accept) begin
      base     <= (new_op == OP_LOAD_HL || new_op == OP_STORE_HL) ? cmd_addr : sp_in;
      pair_src <= pair_in;
      hl_src   <= hl_in;
      pair_out <= pair_in;
      hl_out   <= hl_in;
      sp_out   <= final_sp(new_op, sp_in, hl_in);
    end else if (rd_fire) begin
      if (op_uses_hl(op)) begin
        if (step_high(op, step)) hl_out[2*BW-1:BW] <= mem_rdata;
        else                     hl_out[BW-1:0]    <= mem_rdata;
      end else begin
        if (step_high(op, step)) pair_out[2*BW-1:BW] <= mem_rdata;
        else                     pair_out[BW-1:0]    <= mem_rdata;
      end
    end
  end

  p_swap_sp_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_SWAP_TOP) |-> sp_out == base);
  p_push_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_PUSH) |-> sp_out == base - AW'(2));
  p_store_hl_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_STORE_HL) |-> hl_out == hl_src);
endmodule

// File: rtl/pair_mem_seq.sv
module pair_mem_seq
  import pms_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [2*BW-1:0] pair_in,
  input  logic [2*BW-1:0] hl_in,
  input  logic [AW-1:0]   sp_in,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata,
  input  logic [BW-1:0]   mem_rdata,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            busy,
  output logic            done,
  output logic [2*BW-1:0] pair_out,
  output logic [2*BW-1:0] hl_out,
  output logic [AW-1:0]   sp_out
);
  logic            accept, run, last;
  logic [1:0]      step;
  pms_op_e         op_q;
  logic [AW-1:0]   base;
  logic [2*BW-1:0] pair_src, hl_src;

  pms_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .accept(accept), .run(run), .last(last), .busy(busy), .done(done),
    .step(step), .op_q(op_q)
  );

  pms_agen #(.AW(AW), .BW(BW)) u_agen (
    .run(run), .op(op_q), .step(step), .base(base),
    .pair_src(pair_src), .hl_src(hl_src),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  pms_regs #(.AW(AW), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .done(done), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .pair_in(pair_in), .hl_in(hl_in), .sp_in(sp_in),
    .op(op_q), .step(step), .rd_fire(mem_rd), .mem_rdata(mem_rdata),
    .base(base), .pair_src(pair_src), .hl_src(hl_src),
    .pair_out(pair_out), .hl_out(hl_out), .sp_out(sp_out)
  );

  // access counter used only to check the per-command access count
  logic [2:0] acc_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                acc_cnt <= '0;
    else if (accept)           acc_cnt <= '0;
    else if (mem_rd || mem_wr) acc_cnt <= acc_cnt + 3'd1;
  end

  p_access_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> acc_cnt == op_steps(op_q));
  p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy && !done);
  p_copy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_HL_TO_SP) |-> !(mem_rd || mem_wr));
  p_last_then_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done);
endmodule

// File: tb/pair_mem_seq_tb.sv
module pair_mem_seq_tb;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0;
  logic [2:0]  cmd_op = 0;
  logic [15:0] cmd_addr = 0, pair_in = 0, hl_in = 0, sp_in = 0;
  logic [15:0] mem_addr, pair_out, hl_out, sp_out;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, busy, done;

  logic [7:0] mem [256];
  int tests = 0, fails = 0;

  // access log of the last command
  logic [15:0] la [8];
  logic        lw [8];
  logic [7:0]  ld [8];
  int          nacc, ncyc;

  always #(CLK_NS/2) clk = ~clk;

  pair_mem_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .pair_in(pair_in), .hl_in(hl_in), .sp_in(sp_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .done(done),
    .pair_out(pair_out), .hl_out(hl_out), .sp_out(sp_out)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // run one command; poke=1 raises a copy request while busy
  task automatic issue(logic [2:0] op, logic [15:0] a, logic [15:0] p,
                       logic [15:0] h, logic [15:0] s, bit poke);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; pair_in = p; hl_in = h; sp_in = s; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    nacc = 0; ncyc = 0;
    forever begin
      if (poke && !done) begin cmd_valid = 1; cmd_op = 3'd5; hl_in = 16'hFFFF; end
      else cmd_valid = 0;
      if (busy !== 1'b1) begin chk("R2 busy during command", busy, 1); break; end
      if (mem_rd || mem_wr) begin
        chk("R3 strobes exclusive", mem_rd & mem_wr, 0);
        la[nacc] = mem_addr; lw[nacc] = mem_wr; ld[nacc] = mem_wdata; nacc++;
      end
      if (done) break;
      ncyc++;
      if (ncyc > 10) break;
      @(negedge clk);
    end
    cmd_valid = 0;
    @(negedge clk);
    chk("R2/R3 busy low after done", {busy, done}, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy/done/strobes", {busy, done, mem_rd, mem_wr}, 0);
    chk("R1 outputs zero", {pair_out, hl_out}, 0);
    chk("R1 sp zero", sp_out, 0);
  endtask

  task automatic t_push();
    issue(3'd0, 16'h0, 16'hA55A, 16'h0, 16'h0040, 0);
    chk("R3 push cycles", ncyc, 2);
    chk("R3 push accesses", nacc, 2);
    chk("R4 push first", {la[0], 7'b0, lw[0], ld[0]}, {16'h003F, 8'h01, 8'hA5});
    chk("R4 push second", {la[1], 7'b0, lw[1], ld[1]}, {16'h003E, 8'h01, 8'h5A});
    chk("R4 push sp", sp_out, 16'h003E);
    chk("R4 push mem", {mem[8'h3F], mem[8'h3E]}, 16'hA55A);
  endtask

  task automatic t_pop();
    mem[8'h80] = 8'h11; mem[8'h81] = 8'h22;
    issue(3'd1, 16'h0, 16'h0, 16'h0, 16'h0080, 0);
    chk("R5 pop order", {la[0], la[1], 6'b0, lw[0], lw[1]}, {16'h0080, 16'h0081, 8'h00});
    chk("R5 pop pair", pair_out, 16'h2211);
    chk("R5 pop sp", sp_out, 16'h0082);
  endtask

  task automatic t_swap();
    mem[8'h90] = 8'h33; mem[8'h91] = 8'h44;
    issue(3'd2, 16'h0, 16'h0, 16'hBEEF, 16'h0090, 0);
    chk("R3 swap accesses", nacc, 4);
    chk("R6 swap order", {la[0], la[1], la[2], la[3]},
        {16'h0090, 16'h0091, 16'h0090, 16'h0091});
    chk("R6 swap dirs", {lw[0], lw[1], lw[2], lw[3]}, 4'b0011);
    chk("R6 swap hl", hl_out, 16'h4433);
    chk("R6 swap mem", {mem[8'h91], mem[8'h90]}, 16'hBEEF);
    chk("R6 swap sp kept", sp_out, 16'h0090);
  endtask

  task automatic t_load();
    mem[8'h10] = 8'h9A; mem[8'h11] = 8'h78;
    issue(3'd3, 16'h0010, 16'h0, 16'h5555, 16'h0, 0);
    chk("R7 load hl", hl_out, 16'h789A);
    chk("R7 load no writes", {lw[0], lw[1]}, 0);
    chk("R7 load mem kept", {mem[8'h11], mem[8'h10]}, 16'h789A);
  endtask

  task automatic t_store();
    issue(3'd4, 16'h0020, 16'h0, 16'h1234, 16'h0, 0);
    chk("R8 store mem", {mem[8'h21], mem[8'h20]}, 16'h1234);
    chk("R8 store addrs", {la[0], la[1]}, {16'h0020, 16'h0021});
    chk("R8 store hl kept", hl_out, 16'h1234);
  endtask

  task automatic t_copy();
    issue(3'd5, 16'h0, 16'h0, 16'hCAFE, 16'h1000, 0);
    chk("R9 copy sp", sp_out, 16'hCAFE);
    chk("R9 copy no access", nacc, 0);
    chk("R9 copy done timing", ncyc, 0);
  endtask

  task automatic t_wrap();
    issue(3'd0, 16'h0, 16'h0C3F, 16'h0, 16'h0001, 0);
    chk("R10 push wrap addrs", {la[0], la[1]}, {16'h0000, 16'hFFFF});
    chk("R10 push wrap sp", sp_out, 16'hFFFF);
    issue(3'd1, 16'h0, 16'h0, 16'h0, 16'hFFFF, 0);
    chk("R10 pop wrap pair", pair_out, 16'h0C3F);
    chk("R10 pop wrap sp", sp_out, 16'h0001);
    issue(3'd3, 16'hFFFF, 16'h0, 16'h0, 16'h0, 0);
    chk("R10 load wrap addrs", {la[0], la[1]}, {16'hFFFF, 16'h0000});
  endtask

  task automatic t_ignore();
    issue(3'd0, 16'h0, 16'h0102, 16'h0, 16'h0050, 1);
    chk("R2 ignored while busy sp", sp_out, 16'h004E);
    chk("R2 ignored push accesses", nacc, 2);
    @(negedge clk);
    chk("R2 no late accept", busy, 0);
  endtask

  task automatic t_badcode();
    issue(3'd6, 16'h0, 16'h1357, 16'h2468, 16'h0777, 0);
    chk("R2 unused code no access", nacc, 0);
    chk("R2 unused code outputs", {pair_out, hl_out}, {16'h1357, 16'h2468});
    chk("R2 unused code sp", sp_out, 16'h0777);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_push();
    t_pop();
    t_swap();
    t_load();
    t_store();
    t_copy();
    t_wrap();
    t_ignore();
    t_badcode();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule